// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be handed to the host. When the frame deserialiser signals that a frame is complete, its four identifier bytes sit in a shared background buffer. The filter compares them bit by bit against four programmable acceptance-code bytes. Four mask bytes mark positions that do not matter. Extended frames are judged on all four bytes. Standard frames are judged on bytes 0 and 1 only.

An accepted frame sets a sticky receive-full flag and gives a one-cycle interrupt pulse. A rejected frame leaves no trace, and the buffer is simply reused by the next frame. If a frame is accepted while the previous one is still unread, the new frame is dropped and an overrun flag is raised.

The code and mask bytes sit behind a byte-wide register port. They can be written only while the controller's soft-reset mode input is high. They are not touched by the hardware reset.

Top module: `can_id_filter`

## Requirements
- R1: For an extended frame with an all-zero mask, the frame is accepted only when all 32 identifier bits equal the 32 code bits. Byte n is bits [8n+7:8n] of `id_i` and of the code/mask fields.
- R2: A mask bit of 1 makes that identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R3: A frame whose IDE flag (bit 3 of identifier byte 1, `id_i[11]`) is 0 is a standard frame. It is judged on bytes 0 and 1 only, and bytes 2 and 3 never cause a rejection.
- R4: A frame with IDE = 1 is judged on all four bytes, so a mismatch in byte 2 or byte 3 rejects it.
- R5: A register write to offsets 0–3 (code bytes 0–3) or 4–7 (mask bytes 0–3) takes effect only while `soft_rst_i` is 1. At any other time it leaves the stored byte unchanged.
- R6: The code and mask bytes are not altered by `rst_ni`, and they read back their last written value after a reset.
- R7: When `frame_done_i` is sampled high and the frame is accepted into an empty buffer, `rx_full_o` is 1 and `irq_o` is 1 in the next cycle. `irq_o` lasts exactly one cycle.
- R8: A rejected frame changes neither `rx_full_o` nor `overrun_o`, and it does not pulse `irq_o`.
- R9: `rx_full_o` stays set until the host writes a value with bit 0 = 1 to offset 8. Writing 0 to that bit has no effect.
- R10: An accepted frame that arrives while `rx_full_o` is set raises `overrun_o` and gives no `irq_o`. `rx_full_o` stays 1. `overrun_o` is cleared by writing 1 to bit 1 of offset 8.
- R11: If a host clear of `rx_full_o` and an accepted frame fall in the same cycle, the frame wins: `rx_full_o` stays 1, `irq_o` pulses, and `overrun_o` is not set.
- R12: Offset 8 reads the status byte, with bit 0 = receive full and bit 1 = overrun. Both flags are 0 after `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the status flags |
| soft_rst_i | input | 1 | Controller soft-reset mode; enables code and mask writes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from `reg_addr_i` |
| frame_done_i | input | 1 | One-cycle strobe: a received frame is complete |
| id_i | input | 32 | Identifier bytes of the received frame, byte n at [8n+7:8n] |
| rx_full_o | output | 1 | Sticky flag: accepted frame waiting for the host |
| overrun_o | output | 1 | Sticky flag: an accepted frame was dropped |
| irq_o | output | 1 | One-cycle receive interrupt pulse |

## Verification
Two events can land in the same clock cycle: the host's write-1 clear of the receive-full flag, and the completion of a new accepted frame. The bench provokes this by driving the status write and the frame strobe on the same falling edge while the flag is already set. It then judges the outcome on the next falling edge: the flag must still be set, the interrupt must pulse, and no overrun may be recorded. The opposite case is also run, where an accepted frame arrives with no clear pending, and there the overrun flag must be set.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ID_BYTES  = 4;
  localparam int unsigned STD_BYTES = 2;
  localparam int unsigned IDE_BYTE  = 1;
  localparam int unsigned IDE_BIT   = 3;
  localparam int unsigned ADDR_W    = $clog2(2 * ID_BYTES + 1);
  localparam int unsigned STAT_OFS  = 2 * ID_BYTES;
  localparam int unsigned FULL_BIT  = 0;
  localparam int unsigned OVR_BIT   = 1;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ID_BYTES = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                         clk_i,
  input  logic                         soft_rst_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [BYTE_W-1:0]            wdata_i,
  output logic [ID_BYTES*BYTE_W-1:0]   code_o,
  output logic [ID_BYTES*BYTE_W-1:0]   mask_o
);
  // Retained storage: deliberately no reset term.
  for (genvar b = 0; b < ID_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] code_q, mask_q;
    always_ff @(posedge clk_i) begin
      if (soft_rst_i && we_i && addr_i == ADDR_W'(b))            code_q <= wdata_i;
      if (soft_rst_i && we_i && addr_i == ADDR_W'(b + ID_BYTES)) mask_q <= wdata_i;
    end
    assign code_o[b*BYTE_W +: BYTE_W] = code_q;
    assign mask_o[b*BYTE_W +: BYTE_W] = mask_q;
  end
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ID_BYTES  = 4,
  parameter int unsigned STD_BYTES = 2,
  parameter int unsigned IDE_BYTE  = 1,
  parameter int unsigned IDE_BIT   = 3
) (
  input  logic [ID_BYTES*BYTE_W-1:0] id_i,
  input  logic [ID_BYTES*BYTE_W-1:0] code_i,
  input  logic [ID_BYTES*BYTE_W-1:0] mask_i,
  output logic                       accept_o
);
  localparam int unsigned IDE_POS = IDE_BYTE * BYTE_W + IDE_BIT;

  logic [ID_BYTES-1:0] byte_ok;
  logic [ID_BYTES-1:0] byte_used;
  logic                is_ext;

  assign is_ext = id_i[IDE_POS];

  for (genvar b = 0; b < ID_BYTES; b++) begin : g_cmp
    logic [BYTE_W-1:0] hit;
    assign hit        = ~(id_i[b*BYTE_W +: BYTE_W] ^ code_i[b*BYTE_W +: BYTE_W])
                        | mask_i[b*BYTE_W +: BYTE_W];
    assign byte_ok[b] = &hit;
    if (b < STD_BYTES) begin : g_std
      assign byte_used[b] = 1'b1;
    end else begin : g_ext
      assign byte_used[b] = is_ext;
    end
  end

  assign accept_o = &(byte_ok | ~byte_used);
endmodule

// File: rtl/can_filt_status.sv
module can_filt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_done_i,
  input  logic accept_i,
  input  logic clr_full_i,
  input  logic clr_ovr_i,
  output logic full_o,
  output logic ovr_o,
  output logic irq_o
);
  logic full_q, ovr_q, irq_q;
  logic take, held;

  assign take = frame_done_i & accept_i;
  assign held = full_q & ~clr_full_i;  // clear takes effect before the new frame lands

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= take | held;
      ovr_q  <= (ovr_q & ~clr_ovr_i) | (take & held);
      irq_q  <= take & ~held;
    end
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NB = ID_BYTES,
  parameter int unsigned AW = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [BW-1:0]    reg_wdata_i,
  output logic [BW-1:0]    reg_rdata_o,
  input  logic             frame_done_i,
  input  logic [NB*BW-1:0] id_i,
  output logic             rx_full_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic [NB*BW-1:0] code_flat, mask_flat;
  logic             accept, stat_wr;

  can_filt_regs #(.BYTE_W(BW), .ID_BYTES(NB), .ADDR_W(AW)) u_regs (
    .clk_i     (clk_i),
    .soft_rst_i(soft_rst_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .code_o    (code_flat),
    .mask_o    (mask_flat)
  );

  can_filt_match #(
    .BYTE_W(BW), .ID_BYTES(NB), .STD_BYTES(STD_BYTES),
    .IDE_BYTE(IDE_BYTE), .IDE_BIT(IDE_BIT)
  ) u_match (
    .id_i    (id_i),
    .code_i  (code_flat),
    .mask_i  (mask_flat),
    .accept_o(accept)
  );

  assign stat_wr = reg_we_i && (reg_addr_i == AW'(STAT_OFS));

  can_filt_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(frame_done_i),
    .accept_i    (accept),
    .clr_full_i  (stat_wr & reg_wdata_i[FULL_BIT]),
    .clr_ovr_i   (stat_wr & reg_wdata_i[OVR_BIT]),
    .full_o      (rx_full_o),
    .ovr_o       (overrun_o),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < AW'(NB)) begin
      reg_rdata_o = code_flat[reg_addr_i[$clog2(NB)-1:0]*BW +: BW];
    end else if (reg_addr_i < AW'(2*NB)) begin
      reg_rdata_o = mask_flat[reg_addr_i[$clog2(NB)-1:0]*BW +: BW];
    end else if (reg_addr_i == AW'(STAT_OFS)) begin
      reg_rdata_o[FULL_BIT] = rx_full_o;
      reg_rdata_o[OVR_BIT]  = overrun_o;
    end
  end
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int unsigned BW = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             reg_we_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic [BW-1:0]    reg_wdata_i,
  input logic             frame_done_i,
  input logic             rx_full_o,
  input logic             overrun_o,
  input logic             irq_o,
  input logic [NB*BW-1:0] code_flat,
  input logic [NB*BW-1:0] mask_flat
);
  // R5
  locked_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !soft_rst_i) |=> ($stable(code_flat) && $stable(mask_flat)));

  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_full_o && $past(frame_done_i)));

  // R7
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> ($past(frame_done_i) && irq_o));

  // R9
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(2*NB) && reg_wdata_i[0] && !frame_done_i) |=> !rx_full_o);

  // R10
  overrun_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ($past(rx_full_o) && $past(frame_done_i) && !irq_o));
endmodule

bind can_id_filter can_id_filter_chk #(.BW(BW), .NB(NB), .AW(AW)) chk_i (.*);

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        frame_done_i = 1'b0;
  logic [31:0] id_i = '0;
  logic        rx_full_o, overrun_o, irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  can_id_filter dut_i (.*);

  // {code, mask, id, expected accept}
  localparam logic [96:0] VEC [8] = '{
    {32'h1122_3844, 32'h0000_0000, 32'h1122_3844, 1'b1},  // R1 R4 exact ext
    {32'h1122_3844, 32'h0000_0000, 32'h1123_3844, 1'b0},  // R4 byte2 differs
    {32'h1122_3844, 32'h0001_0000, 32'h1123_3844, 1'b1},  // R2 masked
    {32'h1122_3044, 32'h0000_0000, 32'hFFEE_3044, 1'b1},  // R3 std ignores 2,3
    {32'h1122_3044, 32'h0000_0000, 32'hFFEE_3045, 1'b0},  // R3 byte0 checked
    {32'h1122_3044, 32'h0000_0100, 32'h0000_3144, 1'b1},  // R2 std masked bit
    {32'h1122_3844, 32'hFFFF_FFFF, 32'h0000_0800, 1'b1},  // R2 all don't care
    {32'h1122_3844, 32'h0000_0000, 32'h9122_3844, 1'b0}   // R1 byte3 msb
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic prog(input logic [31:0] code, input logic [31:0] mask);
    soft_rst_i = 1'b1;
    for (int b = 0; b < 4; b++) wr(4'(b), code[b*8 +: 8]);
    for (int b = 0; b < 4; b++) wr(4'(b + 4), mask[b*8 +: 8]);
    soft_rst_i = 1'b0;
  endtask

  // Strobe one frame; returns with outputs of the following cycle visible.
  task automatic frame(input logic [31:0] id);
    @(negedge clk_i);
    frame_done_i = 1'b1; id_i = id;
    @(negedge clk_i);
    frame_done_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12 full", rx_full_o, 0);
    check("R12 ovr", overrun_o, 0);
    check("R7 irq idle", irq_o, 0);
    rst_ni = 1'b1;
    rd(4'd8, d);
    check("R12 status", d, 0);

    foreach (VEC[i]) begin
      prog(VEC[i][96:65], VEC[i][64:33]);
      frame(VEC[i][32:1]);
      check($sformatf("R1-vec%0d full", i), rx_full_o, VEC[i][0]);
      check($sformatf("R7 vec%0d irq", i), irq_o, VEC[i][0]);
      check($sformatf("R8 vec%0d ovr", i), overrun_o, 0);
      @(negedge clk_i);
      check($sformatf("R7 vec%0d irq width", i), irq_o, 0);
      wr(4'd8, 8'h01);
      check($sformatf("R9 vec%0d cleared", i), rx_full_o, 0);
    end

    // R5: writes outside soft reset are ignored
    prog(32'h1122_3844, 32'h0000_0000);
    wr(4'd0, 8'hAA);
    wr(4'd6, 8'h55);
    rd(4'd0, d); check("R5 code kept", d, 8'h44);
    rd(4'd6, d); check("R5 mask kept", d, 8'h00);

    // R6: survive hardware reset
    soft_rst_i = 1'b1; wr(4'd5, 8'h5A); soft_rst_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(4'd5, d); check("R6 mask retained", d, 8'h5A);
    rd(4'd3, d); check("R6 code retained", d, 8'h11);
    prog(32'h1122_3844, 32'h0000_0000);

    // R9: write 0 does nothing
    frame(32'h1122_3844);
    check("R9 set", rx_full_o, 1);
    wr(4'd8, 8'h00);
    check("R9 write0 no clear", rx_full_o, 1);

    // R8: rejected frame while full
    frame(32'h1122_3845);
    check("R8 ovr", overrun_o, 0);
    check("R8 irq", irq_o, 0);
    check("R8 full", rx_full_o, 1);

    // R10: accepted frame while full
    frame(32'h1122_3844);
    check("R10 ovr", overrun_o, 1);
    check("R10 no irq", irq_o, 0);
    check("R10 full", rx_full_o, 1);
    rd(4'd8, d); check("R12 status both", d, 8'h03);
    wr(4'd8, 8'h02);
    check("R10 ovr cleared", overrun_o, 0);
    check("R10 full stays", rx_full_o, 1);

    // R11: clear and accepted frame in one cycle
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'd8; reg_wdata_i = 8'h01;
    frame_done_i = 1'b1; id_i = 32'h1122_3844;
    @(negedge clk_i);
    reg_we_i = 1'b0; frame_done_i = 1'b0;
    check("R11 full", rx_full_o, 1);
    check("R11 irq", irq_o, 1);
    check("R11 ovr", overrun_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule